// File: doc/BRIEF.md
# Key-Serviced Watchdog Timer

This block is a watchdog timer for a low-frequency timebase. A prescaler divides the clock into half-second ticks. A down-counter, once started, is loaded with a programmable number of half-seconds. Software holds the counter off only by writing a two-word key pair to the service register. When the count runs out, the block raises one of two outputs, chosen by a control bit: an internal reset request, or an active-low external reset pin. The output stays asserted until the block is reset.

Software reaches the block through a single-cycle 16-bit register port with byte addresses 0x0, 0x2, 0x4, 0x6 and 0x8. The port holds these controls:
- a run bit that cannot be cleared once set;
- two low-power suspend bits that can be written only once;
- direct software requests for either reset output;
- a pre-expiry interrupt with a write-one-to-clear flag;
- a reset-cause bit that survives the watchdog's own reset and is cleared only by power-on reset;
- a power-down counter, enabled out of reset, that drives the interrupt line low for one clock unless software disables it.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset the registers read as follows: control (0x0) reads 0x0030, interrupt control (0x6) reads 0x0000, miscellaneous (0x8) reads 0x0001 and status (0x4) reads 0x0000. The outputs are inactive: int_rst_req=0, ext_rst_n=1, irq_n=1.
- R2: Writing control bit 2 (run) from 0 to 1 loads the counter with (n+1) half-second ticks, where n is the value written to control bits [15:8]. Expiry becomes visible exactly (n+1)*TICK_DIV clock edges after the write edge.
- R3: The counter reloads only when 0x5555 is written to the service register (0x2) and the next service-register write is 0xAAAA. Any other value, or the reverse order, causes no reload.
- R4: Once control bit 2 is 1, writing 0 to it has no effect. It reads back 1 until reset.
- R5: Control bit 0 (suspend while lp_mode is high) and control bit 7 (suspend while wait_mode is high) take their value only on the first control write after reset; later writes leave them unchanged. While a suspend condition holds, no time elapses.
- R6: On expiry, if control bit 3 is 0 then int_rst_req goes to 1. If bit 3 is 1 then only ext_rst_n goes to 0. The asserted output holds until reset.
- R7: Writing 0 to control bit 4 drives int_rst_req to 1. Writing 0 to control bit 5 drives ext_rst_n to 0. Both take effect on the edge after the write.
- R8: Status bit 1 reads 1 when the last rst was entered while a timeout was asserted. It reads 0 after any other rst and after por.
- R9: Interrupt control bit 14 sets on the tick that leaves exactly m half-seconds to expiry, where m is bits [7:0]. Writing 1 to bit 14 clears it. irq_n is low while bits 15 and 14 are both 1.
- R10: While miscellaneous bit 0 is 1 (its reset value), irq_n goes low for exactly one clock PDC_CYCLES clocks after reset. Writing 0 to bit 0 before then suppresses the pulse.
- R11: Writing the timeout field while running does not change the current countdown. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency block clock |
| rst | input | 1 | Synchronous active-high reset, including the system reset raised by this block |
| por | input | 1 | Synchronous active-high power-on reset; also clears the reset cause |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| lp_mode | input | 1 | Low-power mode indication |
| wait_mode | input | 1 | Wait mode indication |
| int_rst_req | output | 1 | Internal reset request, active high |
| ext_rst_n | output | 1 | External reset output, active low |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The bench builds the block with TICK_DIV=8 and PDC_CYCLES=60, so one half-second tick lasts eight clocks. This makes every timeout, suspend window and pre-expiry point an exact edge count of a few dozen cycles. The bench can therefore check expiry one edge before and at the predicted edge. The short power-down window lets the one-clock interrupt pulse be counted, and lets it be cancelled by a write at the start of each scenario.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int TOUT_W  = 8;
    localparam int COUNT_W = TOUT_W + 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_SERV = 4'h2;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] A_ICTL = 4'h6;
    localparam logic [ADDR_W-1:0] A_MISC = 4'h8;

    localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;

    typedef struct packed {
        logic [TOUT_W-1:0] tout;
        logic              wait_sus;
        logic              spare6;
        logic              ext_drv_n;
        logic              sw_rst_n;
        logic              act_ext;
        logic              run;
        logic              spare1;
        logic              lp_sus;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{tout: '0, wait_sus: 1'b0, spare6: 1'b0,
                                     ext_drv_n: 1'b1, sw_rst_n: 1'b1, act_ext: 1'b0,
                                     run: 1'b0, spare1: 1'b0, lp_sus: 1'b0};

    function automatic logic [COUNT_W-1:0] ticks_of(input logic [TOUT_W-1:0] n);
        return {1'b0, n} + COUNT_W'(1);
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                cause_in,
    input  logic                pre_hit,
    output ctrl_t               ctrl,
    output logic                reload,
    output logic [TOUT_W-1:0]   load_val,
    output logic [TOUT_W-1:0]   pre_sel,
    output logic                irq_act,
    output logic                pdc_en
);

    ctrl_t             ctrl_q;
    ctrl_t             wr_val;
    logic              once_lock;
    logic              armed;
    logic              ie_q;
    logic              flag_q;
    logic [TOUT_W-1:0] ict_q;
    logic              pdc_q;
    logic              wr_ctrl, wr_serv, wr_ictl, wr_misc;
    logic              start, key_ok;

    assign wr_val  = ctrl_t'(bus_wdata);
    assign wr_ctrl = bus_en && bus_we && (bus_addr == A_CTRL);
    assign wr_serv = bus_en && bus_we && (bus_addr == A_SERV);
    assign wr_ictl = bus_en && bus_we && (bus_addr == A_ICTL);
    assign wr_misc = bus_en && bus_we && (bus_addr == A_MISC);

    assign start    = wr_ctrl && wr_val.run && !ctrl_q.run;
    assign key_ok   = wr_serv && (bus_wdata == KEY_FIRE) && armed;
    assign reload   = start || (key_ok && ctrl_q.run);
    assign load_val = start ? wr_val.tout : ctrl_q.tout;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RESET;
            once_lock <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q.tout      <= wr_val.tout;
            ctrl_q.act_ext   <= wr_val.act_ext;
            ctrl_q.sw_rst_n  <= wr_val.sw_rst_n;
            ctrl_q.ext_drv_n <= wr_val.ext_drv_n;
            ctrl_q.run       <= ctrl_q.run | wr_val.run;
            if (!once_lock) begin
                ctrl_q.lp_sus   <= wr_val.lp_sus;
                ctrl_q.wait_sus <= wr_val.wait_sus;
            end
            once_lock <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (wr_serv) begin
            armed <= (bus_wdata == KEY_ARM);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
            ict_q  <= '0;
            pdc_q  <= 1'b1;
        end else begin
            if (wr_ictl) begin
                ie_q  <= bus_wdata[15];
                ict_q <= bus_wdata[TOUT_W-1:0];
            end
            if (pre_hit) begin
                flag_q <= 1'b1;
            end else if (wr_ictl && bus_wdata[14]) begin
                flag_q <= 1'b0;
            end
            if (wr_misc) begin
                pdc_q <= bus_wdata[0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = {14'd0, cause_in, 1'b0};
            A_ICTL:  bus_rdata = {ie_q, flag_q, 6'd0, ict_q};
            A_MISC:  bus_rdata = {15'd0, pdc_q};
            default: bus_rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign pre_sel = ict_q;
    assign irq_act = ie_q && flag_q;
    assign pdc_en  = pdc_q;

    // R4: the run bit never falls outside reset
    a_r4_run_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.run |=> ctrl_q.run);

    // R5: suspend bits frozen after the first control write
    a_r5_once_frozen: assert property (@(posedge clk) disable iff (rst)
        once_lock |=> ($stable(ctrl_q.lp_sus) && $stable(ctrl_q.wait_sus)));

    // R9: the flag only rises after a pre-expiry hit
    a_r9_flag_source: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(pre_hit));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int TICK_DIV = 16384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              suspend,
    input  logic              reload,
    input  logic [TOUT_W-1:0] load_val,
    input  logic [TOUT_W-1:0] pre_sel,
    output logic              expired,
    output logic              pre_hit
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0]   pre_q;
    logic [COUNT_W-1:0] cnt_q;
    logic               adv, tick;

    assign adv  = run && !expired && !suspend;
    assign tick = adv && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            expired <= 1'b0;
        end else if (reload && !expired) begin
            pre_q <= '0;
            cnt_q <= ticks_of(load_val);
        end else if (adv) begin
            if (tick) begin
                pre_q <= '0;
                cnt_q <= cnt_q - COUNT_W'(1);
                if (cnt_q == COUNT_W'(1)) begin
                    expired <= 1'b1;
                end
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    assign pre_hit = tick && !reload && ((cnt_q - COUNT_W'(1)) == {1'b0, pre_sel});

    // R2: count stays within the largest loadable value
    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= COUNT_W'(1 << TOUT_W));

    // R2: expiry only follows the last remaining tick
    a_r2_expiry_from_one: assert property (@(posedge clk) disable iff (rst)
        $rose(expired) |-> $past(cnt_q == COUNT_W'(1)));

    // R6: expiry latched until reset
    a_r6_expiry_held: assert property (@(posedge clk) disable iff (rst)
        expired |=> expired);

endmodule

// File: rtl/wdog_pdc.sv
module wdog_pdc #(
    parameter int PDC_CYCLES = 524288
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic pulse
);

    localparam int CW = $clog2(PDC_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PDC_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            pulse  <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (en && !done_q) begin
                if (cnt_q == LAST) begin
                    done_q <= 1'b1;
                    pulse  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    // R10: the low pulse lasts a single clock
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R10: once fired, the counter never fires again
    a_r10_done_held: assert property (@(posedge clk) disable iff (rst)
        done_q |=> (done_q && !pulse));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TICK_DIV   = 16384,
    parameter int PDC_CYCLES = 524288
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        lp_mode,
    input  logic        wait_mode,
    output logic        int_rst_req,
    output logic        ext_rst_n,
    output logic        irq_n
);

    logic              blk_rst;
    ctrl_t             ctrl;
    logic              reload, expired, pre_hit, irq_act, pdc_en, pdc_pulse;
    logic [TOUT_W-1:0] load_val, pre_sel;
    logic              suspend;
    logic              cause_q, rst_d;

    assign blk_rst = rst || por;
    assign suspend = (ctrl.lp_sus && lp_mode) || (ctrl.wait_sus && wait_mode);

    wdog_regs u_regs (
        .clk       (clk),
        .rst       (blk_rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cause_in  (cause_q),
        .pre_hit   (pre_hit),
        .ctrl      (ctrl),
        .reload    (reload),
        .load_val  (load_val),
        .pre_sel   (pre_sel),
        .irq_act   (irq_act),
        .pdc_en    (pdc_en)
    );

    wdog_core #(.TICK_DIV(TICK_DIV)) u_core (
        .clk      (clk),
        .rst      (blk_rst),
        .run      (ctrl.run),
        .suspend  (suspend),
        .reload   (reload),
        .load_val (load_val),
        .pre_sel  (pre_sel),
        .expired  (expired),
        .pre_hit  (pre_hit)
    );

    wdog_pdc #(.PDC_CYCLES(PDC_CYCLES)) u_pdc (
        .clk   (clk),
        .rst   (blk_rst),
        .en    (pdc_en),
        .pulse (pdc_pulse)
    );

    // Reset cause: sampled when rst rises, cleared only by power-on reset
    always_ff @(posedge clk) begin
        if (por) begin
            cause_q <= 1'b0;
            rst_d   <= 1'b0;
        end else begin
            rst_d <= rst;
            if (rst && !rst_d) begin
                cause_q <= expired;
            end
        end
    end

    assign int_rst_req = (expired && !ctrl.act_ext) || !ctrl.sw_rst_n;
    assign ext_rst_n   = !(expired && ctrl.act_ext) && ctrl.ext_drv_n;
    assign irq_n       = !(irq_act || pdc_pulse);

    // R8: power-on reset always leaves the cause clear
    a_r8_por_clears: assert property (@(posedge clk)
        por |=> !cause_q);

    // R6: with the external action chosen, expiry never requests the internal reset
    a_r6_action_split: assert property (@(posedge clk) disable iff (blk_rst)
        (expired && ctrl.act_ext && ctrl.sw_rst_n) |-> (!int_rst_req && !ext_rst_n));

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

    localparam int TDIV = 8;
    localparam int PDC  = 60;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_SERV = 4'h2;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_ICTL = 4'h6;
    localparam logic [3:0] A_MISC = 4'h8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        lp_mode = 1'b0;
    logic        wait_mode = 1'b0;
    logic        int_rst_req, ext_rst_n, irq_n;

    int cyc = 0;
    int errs = 0;
    int nchk = 0;

    wdog_timer #(.TICK_DIV(TDIV), .PDC_CYCLES(PDC)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .por         (por),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .lp_mode     (lp_mode),
        .wait_mode   (wait_mode),
        .int_rst_req (int_rst_req),
        .ext_rst_n   (ext_rst_n),
        .irq_n       (irq_n)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errs++;
            nchk++;
            $display("FAIL run: watchdog expired (actual hung, expected finished)");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic do_reset(input bit power, input bit keep_pdc);
        @(negedge clk);
        rst = 1'b1; por = power;
        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;
        if (!keep_pdc) wr(A_MISC, 16'h0000);
    endtask

    task automatic t_reset_state;
        logic [15:0] v;
        do_reset(1'b1, 1'b1);
        rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0030);
        rd(A_ICTL, v); chk("R1 ictl", v, 16'h0000);
        rd(A_MISC, v); chk("R1 misc", v, 16'h0001);
        rd(A_STAT, v); chk("R1 stat", v, 16'h0000);
        chk("R1 int_rst_req", 16'(int_rst_req), 16'h0);
        chk("R1 ext_rst_n", 16'(ext_rst_n), 16'h1);
        chk("R1 irq_n", 16'(irq_n), 16'h1);
    endtask

    task automatic t_expire_and_cause;
        logic [15:0] v;
        int t0;
        do_reset(1'b1, 1'b0);
        wr(A_CTRL, 16'h0234);
        t0 = cyc;
        wait_to(t0 + 23); chk("R2 before expiry", 16'(int_rst_req), 16'h0);
        wait_to(t0 + 24); chk("R2 expiry edge", 16'(int_rst_req), 16'h1);
        chk("R6 ext untouched", 16'(ext_rst_n), 16'h1);
        wait_to(t0 + 40); chk("R6 held", 16'(int_rst_req), 16'h1);
        do_reset(1'b0, 1'b0);
        rd(A_STAT, v); chk("R8 cause after timeout", v, 16'h0002);
        do_reset(1'b0, 1'b0);
        rd(A_STAT, v); chk("R8 cleared by plain reset", v, 16'h0000);
        wr(A_CTRL, 16'h0034);
        t0 = cyc;
        wait_to(t0 + 8);
        do_reset(1'b0, 1'b0);
        rd(A_STAT, v); chk("R8 cause again", v, 16'h0002);
        do_reset(1'b1, 1'b0);
        rd(A_STAT, v); chk("R8 cleared by por", v, 16'h0000);
    endtask

    task automatic t_service_keys;
        int t0, t1;
        do_reset(1'b1, 1'b0);
        wr(A_CTRL, 16'h0334);
        t0 = cyc;
        wr(A_SERV, 16'hAAAA);
        wr(A_SERV, 16'h5555);
        wr(A_SERV, 16'h1234);
        wr(A_SERV, 16'hAAAA);
        wait_to(t0 + 31); chk("R3 bad keys no reload (pre)", 16'(int_rst_req), 16'h0);
        wait_to(t0 + 32); chk("R3 bad keys no reload", 16'(int_rst_req), 16'h1);
        do_reset(1'b1, 1'b0);
        wr(A_CTRL, 16'h0334);
        t0 = cyc;
        wait_to(t0 + 20);
        wr(A_SERV, 16'h5555);
        wr(A_SERV, 16'hAAAA);
        t1 = cyc;
        wait_to(t1 + 31); chk("R3 reload delays expiry", 16'(int_rst_req), 16'h0);
        wait_to(t1 + 32); chk("R3 expiry after reload", 16'(int_rst_req), 16'h1);
    endtask

    task automatic t_sticky_suspend;
        logic [15:0] v;
        int tr;
        do_reset(1'b1, 1'b0);
        lp_mode = 1'b1;
        wr(A_CTRL, 16'h0135);
        wr(A_CTRL, 16'h01B0);
        rd(A_CTRL, v); chk("R4 R5 run sticky, once bits frozen", v, 16'h0135);
        repeat (100) @(negedge clk);
        chk("R5 suspended no expiry", 16'(int_rst_req), 16'h0);
        lp_mode = 1'b0;
        tr = cyc;
        wait_to(tr + 15); chk("R5 resume pre", 16'(int_rst_req), 16'h0);
        wait_to(tr + 16); chk("R5 resume expiry", 16'(int_rst_req), 16'h1);
    endtask

    task automatic t_ext_action;
        int t0;
        do_reset(1'b1, 1'b0);
        wr(A_CTRL, 16'h003C);
        t0 = cyc;
        wait_to(t0 + 7); chk("R6 ext pre", 16'(ext_rst_n), 16'h1);
        wait_to(t0 + 8); chk("R6 ext asserted", 16'(ext_rst_n), 16'h0);
        chk("R6 no internal", 16'(int_rst_req), 16'h0);
        wait_to(t0 + 30); chk("R6 ext held", 16'(ext_rst_n), 16'h0);
    endtask

    task automatic t_sw_requests;
        do_reset(1'b1, 1'b0);
        wr(A_CTRL, 16'h0020);
        chk("R7 sw internal request", 16'(int_rst_req), 16'h1);
        chk("R7 ext stays high", 16'(ext_rst_n), 16'h1);
        do_reset(1'b1, 1'b0);
        wr(A_CTRL, 16'h0010);
        chk("R7 sw ext drive", 16'(ext_rst_n), 16'h0);
        chk("R7 internal stays low", 16'(int_rst_req), 16'h0);
    endtask

    task automatic t_pretimeout;
        logic [15:0] v;
        int t0;
        do_reset(1'b1, 1'b0);
        wr(A_ICTL, 16'h8001);
        wr(A_CTRL, 16'h0334);
        t0 = cyc;
        wait_to(t0 + 23);
        rd(A_ICTL, v); chk("R9 flag not yet", v, 16'h8001);
        chk("R9 irq idle", 16'(irq_n), 16'h1);
        wait_to(t0 + 24);
        rd(A_ICTL, v); chk("R9 flag set", v, 16'hC001);
        chk("R9 irq low", 16'(irq_n), 16'h0);
        wr(A_ICTL, 16'hC001);
        rd(A_ICTL, v); chk("R9 flag cleared", v, 16'h8001);
        chk("R9 irq released", 16'(irq_n), 16'h1);
    endtask

    task automatic t_timeout_field;
        int t0, t1;
        do_reset(1'b1, 1'b0);
        wr(A_CTRL, 16'h0234);
        t0 = cyc;
        wr(A_CTRL, 16'h0034);
        wait_to(t0 + 23); chk("R11 field write no effect", 16'(int_rst_req), 16'h0);
        wait_to(t0 + 24); chk("R11 old countdown kept", 16'(int_rst_req), 16'h1);
        do_reset(1'b1, 1'b0);
        wr(A_CTRL, 16'h0034);
        wr(A_CTRL, 16'h0434);
        wr(A_SERV, 16'h5555);
        wr(A_SERV, 16'hAAAA);
        t1 = cyc;
        wait_to(t1 + 39); chk("R11 new value on reload (pre)", 16'(int_rst_req), 16'h0);
        wait_to(t1 + 40); chk("R11 new value on reload", 16'(int_rst_req), 16'h1);
    endtask

    task automatic t_pdc;
        int lows;
        do_reset(1'b1, 1'b1);
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!irq_n) lows++;
        end
        chk("R10 one pulse", 16'(lows), 16'd1);
        do_reset(1'b1, 1'b0);
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!irq_n) lows++;
        end
        chk("R10 disabled no pulse", 16'(lows), 16'd0);
    endtask

    initial begin
        t_reset_state();
        t_expire_and_cause();
        t_service_keys();
        t_sticky_suspend();
        t_ext_action();
        t_sw_requests();
        t_pretimeout();
        t_timeout_field();
        t_pdc();
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

endmodule